// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block fills a 256-entry sprite attribute memory from CPU address space. It has two ways to load that memory. In the slow path, software first writes a pointer register and then writes data bytes one at a time. Each data byte lands at the pointer, and the pointer then steps forward.

In the fast path, software makes one write to a start register. The byte it writes selects a 256-byte page of CPU memory. The engine then takes over the bus and copies the whole page into sprite memory, beginning at the current pointer. Each byte costs one read cycle on the bus-master port, followed by one write cycle on the sprite-memory port.

For the whole run, the CPU is held off the bus through a stall output. The copy always takes exactly 512 cycles. Register writes that arrive while a copy is running are dropped.

Top module: `sprite_page_dma`

## Requirements
- R1: After reset, `busy`, `cpu_stall`, `spr_we` and `src_rd_en` are low, and the sprite pointer is 0x00, so the first data write lands at sprite address 0x00.
- R2: A register write with `reg_sel` = 0 loads the sprite pointer from `reg_wdata`. A write with `reg_sel` = 1 drives a sprite write of `reg_wdata` at the pointer in the following cycle, and the pointer then advances by one.
- R3: The sprite pointer wraps from 0xFF to 0x00.
- R4: A write with `reg_sel` = 2 while idle starts a copy. The source address is `reg_wdata` × 0x100 plus an offset that runs from 0x00 to 0xFF. The 256 bytes go to consecutive sprite addresses starting at the current pointer, wrapping modulo 256. After the copy, the pointer is back at its starting value.
- R5: Each byte is read in one cycle with `src_rd_en` high. In the next cycle, `spr_we` writes the byte returned during that read cycle. Two read cycles never follow one another.
- R6: `cpu_stall` and `busy` rise in the cycle after the start write and stay high for exactly 512 cycles.
- R7: A register write of any kind (start, pointer or data) made while `busy` is high has no effect.
- R8: A write with `reg_sel` = 3 has no effect.
- R9: No source read occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 data, 2 start, 3 spare |
| reg_wdata | input | 8 | Register write data |
| src_rd_en | output | 1 | Bus-master read cycle |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source read data, valid during the read cycle |
| spr_we | output | 1 | Sprite memory write enable |
| spr_addr | output | 8 | Sprite memory write address |
| spr_wdata | output | 8 | Sprite memory write data |
| cpu_stall | output | 1 | Holds the CPU off the bus |
| busy | output | 1 | Copy in progress |

## Verification
Timing is counted from the clock edge that accepts a register write:
- A manual data write appears on the sprite port one cycle after that edge.
- Stall and busy rise one cycle after it.
- During a copy, read cycles fall on odd cycles 1 to 511 counted from the start edge, and each write follows in the next even cycle. Stall and busy drop after cycle 512.

The bench drives inputs on falling edges and samples every output on falling edges. A scoreboard queue holds each expected sprite write, in order, before the stimulus that causes it. The monitor compares each write as it appears, and flags any write the queue did not expect.

// File: rtl/sprite_page_dma_pkg.sv
package sprite_page_dma_pkg;

    typedef enum logic [1:0] {
        SEL_POINTER = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_START   = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_STORE = 2'd2
    } phase_e;

endpackage

// File: rtl/spd_sequencer.sv
module spd_sequencer
    import sprite_page_dma_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fetch
);
    localparam int CNT_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_FETCH;
                    s_d.cnt   = '0;
                end
            end
            PH_FETCH: s_d.phase = PH_STORE;
            PH_STORE: begin
                if (s_q.cnt == CNT_W'(PAGE_BYTES - 1)) begin
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.phase = PH_FETCH;
                    s_d.cnt   = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = (s_q.phase != PH_IDLE);
    assign fetch = (s_q.phase == PH_FETCH);

endmodule

// File: rtl/spd_src_addr.sv
module spd_src_addr #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [DATA_W-1:0]       page_in,
    input  logic                    step,
    output logic [DATA_W+OFF_W-1:0] src_addr
);
    typedef struct packed {
        logic [DATA_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } src_t;

    src_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load) begin
            a_d.page = page_in;
            a_d.off  = '0;
        end else if (step) begin
            a_d.off = a_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign src_addr = {a_q.page, a_q.off};

endmodule

// File: rtl/spd_spr_writer.sv
module spd_spr_writer #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              spr_we,
    output logic [PTR_W-1:0]  spr_addr,
    output logic [DATA_W-1:0] spr_wdata
);
    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              we;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    wr_t w_d, w_q;

    always_comb begin
        w_d    = w_q;
        w_d.we = 1'b0;
        if (wr_en) begin
            w_d.we   = 1'b1;
            w_d.addr = w_q.ptr;
            w_d.data = wr_data;
            w_d.ptr  = w_q.ptr + 1'b1;
        end
        if (ptr_load) begin
            w_d.ptr = ptr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign spr_we    = w_q.we;
    assign spr_addr  = w_q.addr;
    assign spr_wdata = w_q.data;

endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma
    import sprite_page_dma_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 256
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     reg_wr,
    input  logic [1:0]                               reg_sel,
    input  logic [DATA_W-1:0]                        reg_wdata,
    output logic                                     src_rd_en,
    output logic [DATA_W+$clog2(PAGE_BYTES)-1:0]     src_addr,
    input  logic [DATA_W-1:0]                        src_rdata,
    output logic                                     spr_we,
    output logic [$clog2(PAGE_BYTES)-1:0]            spr_addr,
    output logic [DATA_W-1:0]                        spr_wdata,
    output logic                                     cpu_stall,
    output logic                                     busy
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PTR_W  = OFF_W;
    localparam int ADDR_W = DATA_W + OFF_W;

    logic              run;
    logic              fetch;
    logic              wr_ok;
    logic              start;
    logic              ptr_load;
    logic              man_wr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    assign wr_ok    = reg_wr && !run;
    assign start    = wr_ok && (reg_sel == SEL_START);
    assign ptr_load = wr_ok && (reg_sel == SEL_POINTER);
    assign man_wr   = wr_ok && (reg_sel == SEL_DATA);
    assign wr_en    = man_wr || fetch;
    assign wr_data  = fetch ? src_rdata : reg_wdata;

    spd_sequencer #(
        .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (run),
        .fetch (fetch)
    );

    spd_src_addr #(
        .DATA_W(DATA_W),
        .OFF_W (OFF_W)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .page_in  (reg_wdata),
        .step     (fetch),
        .src_addr (src_addr)
    );

    spd_spr_writer #(
        .DATA_W(DATA_W),
        .PTR_W (PTR_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_load),
        .ptr_val   (reg_wdata[PTR_W-1:0]),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .spr_we    (spr_we),
        .spr_addr  (spr_addr),
        .spr_wdata (spr_wdata)
    );

    assign src_rd_en = fetch;
    assign cpu_stall = run;
    assign busy      = run;

endmodule

// File: rtl/sprite_page_dma_chk.sv
module sprite_page_dma_chk #(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic              busy,
    input logic              cpu_stall,
    input logic              src_rd_en,
    input logic [ADDR_W-1:0] src_addr,
    input logic              spr_we
);
    localparam int RUN_CYCLES = 2 * PAGE_BYTES;
    localparam int RUN_W      = $clog2(RUN_CYCLES) + 2;

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_read_then_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |=> (spr_we && !src_rd_en));

    assert_idle_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !src_rd_en);

    assert_first_offset_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (src_rd_en && (src_addr[OFF_W-1:0] == '0)));

    assert_offset_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_en && $past(busy) && $past(src_rd_en, 2)) |->
        (src_addr[OFF_W-1:0] == OFF_W'($past(src_addr[OFF_W-1:0], 2) + 1'b1)));

    assert_page_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(src_addr[ADDR_W-1:OFF_W]));

    assert_stall_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == 2'd2) && !busy) |=> cpu_stall);

    assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> (run_len == RUN_W'(RUN_CYCLES)));

endmodule

bind sprite_page_dma sprite_page_dma_chk #(
    .PAGE_BYTES(PAGE_BYTES),
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .busy      (busy),
    .cpu_stall (cpu_stall),
    .src_rd_en (src_rd_en),
    .src_addr  (src_addr),
    .spr_we    (spr_we)
);

// File: tb/sprite_page_dma_bench.sv
module sprite_page_dma_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        src_rd_en;
    logic [15:0] src_addr;
    logic [7:0]  src_rdata;
    logic        spr_we;
    logic [7:0]  spr_addr;
    logic [7:0]  spr_wdata;
    logic        cpu_stall;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] exp_ptr = 8'h00;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      req;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] src_byte(logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign src_rdata = src_byte(src_addr);

    sprite_page_dma u_sprite_page_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .src_rd_en (src_rd_en),
        .src_addr  (src_addr),
        .src_rdata (src_rdata),
        .spr_we    (spr_we),
        .spr_addr  (spr_addr),
        .spr_wdata (spr_wdata),
        .cpu_stall (cpu_stall),
        .busy      (busy)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each sprite write against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && spr_we) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7", "unexpected sprite write addr", int'(spr_addr), 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk((spr_addr == it.a) && (spr_wdata == it.d), it.req,
                    "sprite write addr/data", int'({spr_addr, spr_wdata}), int'({it.a, it.d}));
            end
        end
    end

    task automatic reg_write(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic data_write(logic [7:0] d, string req);
        sb.push_back('{a: exp_ptr, d: d, req: req});
        exp_ptr = exp_ptr + 8'd1;
        reg_write(2'd1, d);
    endtask

    task automatic run_copy(logic [7:0] page, bit interfere);
        int cycles;
        int pattern_bad;
        for (int i = 0; i < 256; i++) begin
            sb.push_back('{a: 8'(exp_ptr + 8'(i)), d: src_byte({page, 8'(i)}), req: "R4"});
        end
        @(negedge clk);
        reg_wr = 1'b1;
        reg_sel = 2'd2;
        reg_wdata = page;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(cpu_stall && busy, "R6", "stall/busy in cycle after start", int'({cpu_stall, busy}), 3);
        cycles = 0;
        pattern_bad = 0;
        fork
            begin
                while (cpu_stall && cycles < 2000) begin
                    cycles++;
                    if (src_rd_en != cycles[0]) pattern_bad++;
                    if (src_rd_en && src_addr != {page, 8'((cycles - 1) / 2)}) pattern_bad++;
                    @(negedge clk);
                end
            end
            begin
                if (interfere) begin
                    repeat (100) @(negedge clk);
                    reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h77;
                    @(negedge clk);
                    reg_sel = 2'd0; reg_wdata = 8'h05;
                    @(negedge clk);
                    reg_sel = 2'd1; reg_wdata = 8'hEE;
                    @(negedge clk);
                    reg_wr = 1'b0;
                end
            end
        join
        chk(cycles == 512, "R6", "stall cycle count", cycles, 512);
        chk(pattern_bad == 0, "R5", "read/write alternation and source address", pattern_bad, 0);
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R4", "bytes left unwritten", sb.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cpu_stall, "R1", "busy/stall after reset", int'({busy, cpu_stall}), 0);
        chk(!spr_we && !src_rd_en, "R1", "write/read after reset", int'({spr_we, src_rd_en}), 0);

        // R1: pointer starts at zero
        data_write(8'h5A, "R1");

        // R2: pointer load and data writes
        reg_write(2'd0, 8'h10);
        exp_ptr = 8'h10;
        data_write(8'h11, "R2");
        data_write(8'h22, "R2");
        data_write(8'h33, "R2");

        // R3: pointer wrap
        reg_write(2'd0, 8'hFE);
        exp_ptr = 8'hFE;
        data_write(8'hA0, "R3");
        data_write(8'hA1, "R3");
        data_write(8'hA2, "R3");

        // R8: spare select does nothing
        reg_write(2'd3, 8'h55);
        repeat (2) @(negedge clk);
        chk(!spr_we && !busy && !src_rd_en, "R8", "spare write activity", int'({spr_we, busy, src_rd_en}), 0);
        data_write(8'hB4, "R8");

        // R9: idle reads
        chk(!src_rd_en, "R9", "read while idle", int'(src_rd_en), 0);

        // R4: copy from page 0x02 at pointer 0x00
        reg_write(2'd0, 8'h00);
        exp_ptr = 8'h00;
        run_copy(8'h02, 1'b0);
        data_write(8'hC1, "R4");

        // R7: copy with wrapped pointer and writes during the run
        reg_write(2'd0, 8'h40);
        exp_ptr = 8'h40;
        run_copy(8'hC3, 1'b1);
        chk(!busy, "R7", "late start did not launch a second copy", int'(busy), 0);
        data_write(8'h99, "R7");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R7", "pending expected writes", sb.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule